// File: doc/BRIEF.md
# Register-Pointer Two-Wire Bus Slave

This block is a slave on an open-drain two-wire serial bus (I2C). It answers one fixed 7-bit address and gives the bus master access to a small bank of 8-bit registers through an internal register pointer. Both bus lines are oversampled by the system clock. A two-flop synchronizer comes first, and then START, STOP and clock edges are found in the system clock domain. The system clock must run at least 8 times faster than the bus clock.

A write transaction carries a pointer byte first, and every later byte is stored at the pointer, which then advances. A read transaction streams registers out from the pointer, most significant bit first. It keeps going for as long as the master acknowledges. The `rdy_i` input is the block's back-pressure. While it is low and the slave is selected, the slave holds the bus clock low after each falling edge. The master cannot start the next bit until `rdy_i` returns high. The slave never drives a line high: each output is a pull-low enable for an external open-drain driver.

Top module: `i2c_reg_slave`

## Requirements
- R1: While reset is asserted, and afterwards until the slave is addressed, both pull-low enables stay deasserted.
- R2: The first byte after a START is {address[6:0], dir}, where dir 0 means write and dir 1 means read. When the address equals `SLV_ADDR`, the slave pulls SDA low through the ninth clock.
- R3: When the address does not match, the slave acknowledges neither the address nor any later byte, and it leaves every register unchanged until the next START.
- R4: In a write, the first data byte loads the pointer and the next byte is stored in the register the pointer selects. Every byte is acknowledged.
- R5: Each further data byte in the same write goes to the next register, because the pointer advances after every stored byte.
- R6: In a read, the slave sends the register at the pointer MSB first, changing SDA only after SCL falls. The pointer advances after each byte sent. A repeated START after a pointer write keeps the pointer.
- R7: When the master answers a read byte with NACK, the slave releases SDA and sends nothing more until the next START.
- R8: While the slave is selected and `rdy_i` is low, it pulls SCL low after the next SCL falling edge. It keeps SCL low until `rdy_i` goes high.
- R9: A START or STOP in the middle of a byte aborts it. The next transaction is decoded from its first bit.
- R10: Outputs are active-high pull-low enables. SDA is never pulled while the slave is idle or ignoring the bus.
- R11: The pointer uses the low log2(`NREG`) bits of the pointer byte and wraps from `NREG`-1 to 0, for both writes and reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| rdy_i | input | 1 | Internal logic ready; low stretches the bus clock |
| scl_pull_o | output | 1 | 1 = pull the clock line low |
| sda_pull_o | output | 1 | 1 = pull the data line low |

## Verification
The bench builds the block with `SLV_ADDR` = 7'h2A and `NREG` = 4. With only four registers, pointer wrap on both writes and multi-byte reads comes up within a few bytes. The bench's bus master runs at one twentieth of the system clock, so the synchronizer latency of a few cycles fits well inside each bus half-period. That leaves room to observe a held clock while `rdy_i` is low, and to abort a byte with a STOP after three bits.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACKA, S_WR, S_ACKW, S_RD, S_RACK, S_IGN
  } st_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] lvl,
  output logic [LANES-1:0] rise,
  output logic [LANES-1:0] fall
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], din[g]};
    end
    assign lvl[g]  = sh[STAGES-1];
    assign rise[g] = sh[STAGES-1] & ~sh[STAGES];
    assign fall[g] = ~sh[STAGES-1] & sh[STAGES];
  end
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
#(
  parameter int NREG = 4,
  localparam int PW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PW-1:0]     waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [PW-1:0]     raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                          bank[g] <= '0;
      else if (we && waddr == PW'(g))      bank[g] <= wdata;
    end
  end

  assign rdata = bank[raddr];

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we); // R4
endmodule

// File: rtl/i2cs_core.sv
module i2cs_core
  import i2cs_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h2A,
  parameter int NREG = 4,
  localparam int PW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic              rdy,
  input  logic [BYTE_W-1:0] rdata,
  output logic [PW-1:0]     raddr,
  output logic              we,
  output logic [PW-1:0]     waddr,
  output logic [BYTE_W-1:0] wdata,
  output logic              sda_pull,
  output logic              scl_pull
);
  localparam logic [PW-1:0] LAST = PW'(NREG - 1);

  st_e               st;
  logic [2:0]        bitc;
  logic [BYTE_W-1:0] sr, tx;
  logic [PW-1:0]     ptr;
  logic              rw, got, need_ptr, nack;
  logic              start_ev, stop_ev, engaged;

  assign start_ev = scl_lvl & sda_fall;
  assign stop_ev  = scl_lvl & sda_rise;
  assign engaged  = st inside {S_ACKA, S_WR, S_ACKW, S_RD, S_RACK};
  assign raddr    = ptr;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; bitc <= '0; sr <= '0; tx <= '0; ptr <= '0;
      rw <= 1'b0; got <= 1'b0; need_ptr <= 1'b0; nack <= 1'b0;
      sda_pull <= 1'b0; we <= 1'b0; waddr <= '0; wdata <= '0;
    end else begin
      we <= 1'b0;
      if (start_ev) begin
        st <= S_ADDR; bitc <= '0; got <= 1'b0; sda_pull <= 1'b0;
      end else if (stop_ev) begin
        st <= S_IDLE; got <= 1'b0; sda_pull <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WR: begin
            if (scl_rise) begin
              sr   <= {sr[BYTE_W-2:0], sda_lvl};
              bitc <= bitc + 1'b1;
              if (bitc == 3'd7) got <= 1'b1;
            end else if (scl_fall && got) begin
              got  <= 1'b0;
              bitc <= '0;
              if (st == S_ADDR) begin
                if (sr[7:1] == SLV_ADDR) begin
                  st <= S_ACKA; sda_pull <= 1'b1;
                  rw <= sr[0]; need_ptr <= ~sr[0];
                end else begin
                  st <= S_IGN;
                end
              end else begin
                st <= S_ACKW; sda_pull <= 1'b1;
                if (need_ptr) begin
                  ptr <= sr[PW-1:0]; need_ptr <= 1'b0;
                end else begin
                  we <= 1'b1; waddr <= ptr; wdata <= sr; ptr <= step(ptr);
                end
              end
            end
          end
          S_ACKA: if (scl_fall) begin
            bitc <= '0;
            if (rw) begin
              st <= S_RD; tx <= rdata; sda_pull <= ~rdata[BYTE_W-1];
              ptr <= step(ptr);
            end else begin
              st <= S_WR; sda_pull <= 1'b0;
            end
          end
          S_ACKW: if (scl_fall) begin
            st <= S_WR; sda_pull <= 1'b0; bitc <= '0;
          end
          S_RD: if (scl_fall) begin
            if (bitc == 3'd7) begin
              st <= S_RACK; sda_pull <= 1'b0;
            end else begin
              bitc <= bitc + 1'b1;
              tx <= tx << 1;
              sda_pull <= ~tx[BYTE_W-2];
            end
          end
          S_RACK: begin
            if (scl_rise) nack <= sda_lvl;
            else if (scl_fall) begin
              if (nack) st <= S_IGN;
              else begin
                st <= S_RD; tx <= rdata; sda_pull <= ~rdata[BYTE_W-1];
                ptr <= step(ptr); bitc <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   scl_pull <= 1'b0;
    else if (start_ev || stop_ev) scl_pull <= 1'b0;
    else if (rdy)                 scl_pull <= 1'b0;
    else if (scl_fall && engaged) scl_pull <= 1'b1;
  end

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && !rdy && !start_ev && !stop_ev) |=> scl_pull); // R8
  AST_STRETCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> !$past(rdy)); // R8
  AST_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_IGN) |-> !sda_pull); // R10
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == S_ADDR)); // R9
  AST_MISMATCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && scl_fall && got && sr[7:1] != SLV_ADDR && !start_ev && !stop_ev)
      |=> (st == S_IGN && !sda_pull)); // R3
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2cs_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h2A,
  parameter int NREG = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic rdy_i,
  output logic scl_pull_o,
  output logic sda_pull_o
);
  localparam int PW = $clog2(NREG);

  logic [1:0]        lvl, rise, fall;
  logic              we;
  logic [PW-1:0]     waddr, raddr;
  logic [BYTE_W-1:0] wdata, rdata;

  i2cs_sync #(.LANES(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sda_i, scl_i}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  i2cs_core #(.SLV_ADDR(SLV_ADDR), .NREG(NREG)) u_core (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(lvl[0]), .scl_rise(rise[0]), .scl_fall(fall[0]),
    .sda_lvl(lvl[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
    .rdy(rdy_i), .rdata(rdata), .raddr(raddr),
    .we(we), .waddr(waddr), .wdata(wdata),
    .sda_pull(sda_pull_o), .scl_pull(scl_pull_o)
  );

  i2cs_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  localparam logic [6:0] ADR = 7'h2A;
  localparam int HALF = 10;
  localparam int QTR  = 5;
  localparam logic [15:0] VEC [4] = '{16'h005A, 16'h01C3, 16'h020F, 16'h03A5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, rdy = 1'b1;
  logic scl_pull, sda_pull;
  logic scl, sda;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic a0, a1, a2, a3;
  logic [7:0] d0, d1;

  assign scl = scl_m & ~scl_pull;
  assign sda = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  i2c_reg_slave #(.SLV_ADDR(ADR), .NREG(4)) i_i2c_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .rdy_i(rdy),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up;
    scl_m = 1'b1;
    while (scl !== 1'b1) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wclk(QTR); scl_up; wclk(QTR);
    sda_m = 1'b0; wclk(QTR); scl_m = 1'b0; wclk(QTR);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wclk(QTR); scl_up; wclk(QTR);
    sda_m = 1'b1; wclk(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wclk(QTR); scl_up; wclk(HALF); scl_m = 1'b0; wclk(QTR);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wclk(QTR); scl_up; wclk(QTR);
    b = sda; wclk(QTR); scl_m = 1'b0; wclk(QTR);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] v);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      v[i] = x;
    end
    send_bit(~m_ack);
  endtask

  task automatic write1(input logic [7:0] p, input logic [7:0] v);
    logic k0, k1, k2;
    bus_start;
    send_byte({ADR, 1'b0}, k0);
    send_byte(p, k1);
    send_byte(v, k2);
    bus_stop;
    chk("R2 addr ack", k0, 1);
    chk("R4 ptr ack", k1, 1);
    chk("R4 data ack", k2, 1);
  endtask

  task automatic read1(input logic [7:0] p, output logic [7:0] v);
    logic k0, k1, k2;
    bus_start;
    send_byte({ADR, 1'b0}, k0);
    send_byte(p, k1);
    bus_start;
    send_byte({ADR, 1'b1}, k2);
    recv_byte(1'b0, v);
    bus_stop;
    chk("R9 rd setup ack", {k0, k1, k2}, 3'b111);
  endtask

  initial begin
    wclk(3);
    chk("R1 reset scl_pull", scl_pull, 0);
    chk("R1 reset sda_pull", sda_pull, 0);
    rst_n = 1'b1;
    wclk(20);
    chk("R1 idle pulls", {scl_pull, sda_pull}, 0);

    // table walk: single-register writes, then read-back (R4, R6)
    foreach (VEC[i]) write1(VEC[i][15:8], VEC[i][7:0]);
    foreach (VEC[i]) begin
      read1(VEC[i][15:8], d0);
      chk("R6 readback", d0, VEC[i][7:0]);
    end

    // R5 multi-byte write, R6 multi-byte read with auto-increment
    bus_start;
    send_byte({ADR, 1'b0}, a0); send_byte(8'h01, a1);
    send_byte(8'h11, a2); send_byte(8'h22, a3);
    bus_stop;
    chk("R5 burst acks", {a0, a1, a2, a3}, 4'hF);
    bus_start;
    send_byte({ADR, 1'b0}, a0); send_byte(8'h01, a1);
    bus_start;
    send_byte({ADR, 1'b1}, a2);
    recv_byte(1'b1, d0); recv_byte(1'b0, d1);
    bus_stop;
    chk("R5 reg1", d0, 8'h11);
    chk("R6 autoinc reg2", d1, 8'h22);

    // R11 wrap on write and on read
    bus_start;
    send_byte({ADR, 1'b0}, a0); send_byte(8'h07, a1);
    send_byte(8'hB3, a2); send_byte(8'hB0, a3);
    bus_stop;
    bus_start;
    send_byte({ADR, 1'b0}, a0); send_byte(8'h03, a1);
    bus_start;
    send_byte({ADR, 1'b1}, a2);
    recv_byte(1'b1, d0); recv_byte(1'b0, d1);
    bus_stop;
    chk("R11 reg3", d0, 8'hB3);
    chk("R11 wrap to reg0", d1, 8'hB0);

    // R3 address mismatch
    bus_start;
    send_byte({7'h23, 1'b0}, a0); send_byte(8'h00, a1); send_byte(8'h55, a2);
    bus_stop;
    chk("R3 no acks", {a0, a1, a2}, 0);
    read1(8'h00, d0);
    chk("R3 reg0 untouched", d0, 8'hB0);

    // R7 NACK then extra clocks: slave must stay released
    bus_start;
    send_byte({ADR, 1'b0}, a0); send_byte(8'h02, a1);
    bus_start;
    send_byte({ADR, 1'b1}, a2);
    recv_byte(1'b0, d0);
    recv_byte(1'b0, d1);
    bus_stop;
    chk("R7 byte before nack", d0, 8'h22);
    chk("R7 released after nack", d1, 8'hFF);

    // R9 STOP in mid-byte, then clean transaction
    bus_start;
    send_byte({ADR, 1'b0}, a0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop;
    chk("R9 pulls after abort", {scl_pull, sda_pull}, 0);
    write1(8'h01, 8'h77);
    read1(8'h01, d0);
    chk("R9 after abort", d0, 8'h77);

    // R8 clock stretching
    rdy = 1'b0;
    bus_start;
    send_byte({ADR, 1'b0}, a0);
    fork
      send_byte(8'h02, a1);
      begin
        wclk(60);
        chk("R8 scl held low", scl, 0);
        chk("R8 pull asserted", scl_pull, 1);
        rdy = 1'b1;
      end
    join
    send_byte(8'h9C, a2);
    bus_stop;
    chk("R8 acks", {a0, a1, a2}, 3'b111);
    read1(8'h02, d0);
    chk("R8 data stored", d0, 8'h9C);
    chk("R10 idle sda", sda_pull, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule